// File: doc/BRIEF.md
# Programmable-Length Recirculating Shift Register

This block holds one pattern field and replays it one bit per shift. The pattern lives in the flip-flops themselves: every bit that leaves the last stage is written back into the stage where the loop begins. The pattern therefore survives every pass, and no separate storage is needed. The chain has `MAX_LEN` stages, and each stage has a two-input multiplexer in front of it. A run-time length code picks which stage takes the wrap-around path, so the loop covers only the last `L` stages of the chain.

Loading uses the same path. In load mode the loop-start stage takes the serial input instead of the feedback. After `L` load shifts, the first bit written stands at the output. In run mode the field is played out in load order. An end-of-field strobe marks the shift that presents the last bit of each pass, so a sequencer outside the block can count repeats.

Top module: `rsr_loop_shifter`

## Requirements
- R1: During and after reset, all stages and the position counter are zero, so `ser_out` is 0 and `end_of_field` is 0 while `shift_en` is low.
- R2: With `load_mode`=1 and `shift_en`=1, each clock writes `ser_in` into the loop-start stage. After exactly L such shifts, `ser_out` shows the first bit loaded.
- R3: With `load_mode`=0 and `shift_en`=1, each clock advances `ser_out` to the next loaded bit, in the order the bits were loaded. After the last bit it returns to the first, so the field repeats unchanged every L shifts.
- R4: Any length code from 1 to MAX_LEN gives a loop of exactly that many bits, including 1 and MAX_LEN.
- R5: A length code of 0 behaves exactly as a length code of 1.
- R6: A length code above MAX_LEN behaves exactly as MAX_LEN.
- R7: While `shift_en` is low, `ser_out` and the field position hold. When shifting resumes, playback continues with the bit that was pending.
- R8: `end_of_field` is 1 in a run-mode shift cycle exactly when `ser_out` shows bit L-1 of the field (the last one loaded). This happens once per L shifts, and on every shift when L is 1.
- R9: `end_of_field` is 0 whenever `shift_en` is low or `load_mode` is high.
- R10: Any load shift restarts the field position, so the first run shift after a load presents bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_mode | input | 1 | 1: serial input feeds the loop start; 0: recirculate |
| shift_en | input | 1 | Advances the chain by one stage when high |
| len_code | input | LEN_W (7) | Loop length; 0 is read as 1, values above MAX_LEN are read as MAX_LEN |
| ser_in | input | 1 | Serial data written during load shifts |
| ser_out | output | 1 | Current pattern bit (last stage of the chain) |
| end_of_field | output | 1 | High during the shift that presents the last bit of a pass |

## Verification
The bench builds the block with the default MAX_LEN of 64 and LEN_W of 7. The 7-bit code can then express 0 and values well above 64, so both clamping rules can be driven directly, and the full-length loop of 64 stages can be filled and replayed twice over. Short loops of 1, 5 and 8 bits, plus a 63-bit loop, cover the stage-select decode at both ends and in the middle. Pauses inserted in the middle of a pass check that position and data are held.

// File: rtl/rsr_pkg.sv
// Package rsr_pkg
// Shared definitions for the recirculating shift register.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package rsr_pkg;

    // Source selected by the front-end of the loop-start stage.
    typedef enum logic {
        LOOP_SRC_FEEDBACK = 1'b0,
        LOOP_SRC_SERIAL   = 1'b1
    } loop_src_e;

endpackage

// File: rtl/rsr_len_decode.sv
// Module rsr_len_decode
// Turns a raw length code into an effective length (clamped to 1..MAX_LEN),
// the index of the last field bit, and a one-hot vector marking the stage
// that closes the loop (stage MAX_LEN - L).
// Assumes MAX_LEN >= 2 and LEN_W wide enough to hold MAX_LEN.
module rsr_len_decode #(
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int POS_W   = $clog2(MAX_LEN)
) (
    input  logic [LEN_W-1:0]   len_code,
    output logic [POS_W-1:0]   last_idx,
    output logic [MAX_LEN-1:0] start_oh
);

    localparam logic [LEN_W-1:0] LEN_MAX_C = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_ONE_C = LEN_W'(1);

    logic [LEN_W-1:0] leff;
    logic [LEN_W-1:0] leff_m1;

    // Clamp the code into the legal range 1..MAX_LEN.
    always_comb begin
        if (len_code == '0)
            leff = LEN_ONE_C;
        else if (len_code > LEN_MAX_C)
            leff = LEN_MAX_C;
        else
            leff = len_code;
    end

    // Index of the final bit of a pass.
    assign leff_m1  = leff - LEN_ONE_C;
    assign last_idx = leff_m1[POS_W-1:0];

    // Stage i closes the loop when the loop covers stages i..MAX_LEN-1.
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_start
        assign start_oh[i] = (leff == LEN_W'(MAX_LEN - i));
    end

endmodule

// File: rtl/rsr_stage.sv
// Module rsr_stage
// One storage stage: a 2:1 multiplexer choosing between the chain input
// (previous stage or serial input) and the loop source, followed by a
// D flip-flop that updates only when enabled.
// Assumes synchronous active-low reset.
module rsr_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_loop,
    input  logic chain_d,
    input  logic loop_d,
    output logic q
);

    logic d_mux;

    // Front-end multiplexer.
    assign d_mux = sel_loop ? loop_d : chain_d;

    // Storage flip-flop with hold when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (en)
            q <= d_mux;
    end

    // R3
    loop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && sel_loop |=> q == $past(loop_d));

    // R7
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

endmodule

// File: rtl/rsr_pos_ctr.sv
// Module rsr_pos_ctr
// Tracks which field bit is at the output. Cleared by any load shift,
// advanced by each run shift, wrapping after the last index. If the length
// shrinks below the current position, the next advance wraps to zero.
module rsr_pos_ctr #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [POS_W-1:0] last_idx,
    output logic             at_last
);

    logic [POS_W-1:0] pos_q;

    // Position register: clear on load, step and wrap on run shifts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (clr)
            pos_q <= '0;
        else if (adv) begin
            if (pos_q >= last_idx)
                pos_q <= '0;
            else
                pos_q <= pos_q + POS_W'(1);
        end
    end

    // Flag that the output currently holds the last bit of the pass.
    assign at_last = (pos_q == last_idx);

    // R10
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pos_q == '0);

    // R8
    pass_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !clr && at_last |=> pos_q == '0);

    // R7
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !clr |=> $stable(pos_q));

endmodule

// File: rtl/rsr_loop_shifter.sv
// Module rsr_loop_shifter (top)
// Variable-length recirculating shift register. MAX_LEN stages form a chain
// whose last stage drives ser_out. The stage picked by the length code takes
// the loop source: the serial input in load mode, the last stage otherwise.
// Assumes len_code is stable during a pass; changing it mid-pass restarts
// at a loop boundary only on the next load.
module rsr_loop_shifter #(
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_mode,
    input  logic             shift_en,
    input  logic [LEN_W-1:0] len_code,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             end_of_field
);

    import rsr_pkg::*;

    localparam int POS_W = $clog2(MAX_LEN);

    logic [MAX_LEN-1:0] stg_q;
    logic [MAX_LEN-1:0] chain_d;
    logic [MAX_LEN-1:0] start_oh;
    logic [POS_W-1:0]   last_idx;
    loop_src_e          loop_sel;
    logic               loop_d;
    logic               run_shift;
    logic               load_shift;
    logic               at_last;

    // Qualify shift kinds.
    assign run_shift  = shift_en && !load_mode;
    assign load_shift = shift_en && load_mode;

    // Loop source: serial data while loading, wrap-around otherwise.
    assign loop_sel = load_mode ? LOOP_SRC_SERIAL : LOOP_SRC_FEEDBACK;
    assign loop_d   = (loop_sel == LOOP_SRC_SERIAL) ? ser_in : stg_q[MAX_LEN-1];

    rsr_len_decode #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .POS_W   (POS_W)
    ) u_len (
        .len_code (len_code),
        .last_idx (last_idx),
        .start_oh (start_oh)
    );

    // Chain of stages; stage 0 takes the serial input on its chain side.
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign chain_d[i] = ser_in;
        end else begin : g_body
            assign chain_d[i] = stg_q[i-1];
        end

        rsr_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (shift_en),
            .sel_loop (start_oh[i]),
            .chain_d  (chain_d[i]),
            .loop_d   (loop_d),
            .q        (stg_q[i])
        );
    end

    rsr_pos_ctr #(
        .POS_W (POS_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load_shift),
        .adv      (run_shift),
        .last_idx (last_idx),
        .at_last  (at_last)
    );

    // Output taps.
    assign ser_out      = stg_q[MAX_LEN-1];
    assign end_of_field = run_shift && at_last;

    // R9
    eof_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_field |-> shift_en && !load_mode);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ser_out));

    // R3
    recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_shift |=> stg_q[MAX_LEN - 1 - int'(last_idx)] == $past(ser_out));

endmodule

// File: tb/rsr_loop_shifter_tb.sv
`timescale 1ns/1ps
module rsr_loop_shifter_tb;

    localparam int MAX_LEN = 64;
    localparam int LEN_W   = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_mode = 1'b0;
    logic             shift_en = 1'b0;
    logic [LEN_W-1:0] len_code = '0;
    logic             ser_in = 1'b0;
    logic             ser_out;
    logic             end_of_field;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected {ser_out, end_of_field} for each run shift.
    logic [1:0] exp_q[$];

    always #2 clk = ~clk;

    rsr_loop_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .shift_en(shift_en),
        .len_code(len_code), .ser_in(ser_in), .ser_out(ser_out),
        .end_of_field(end_of_field)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare every run shift against the scoreboard; loads must not strobe.
    always @(negedge clk) begin
        if (rst_n && shift_en && !load_mode) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R3 actual=unexpected_shift expected=none at %0t", $time);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk("R3 data", ser_out, e[1]);
                chk("R8 end_of_field", end_of_field, e[0]);
            end
        end else if (rst_n && shift_en && load_mode) begin
            chk("R9 eof in load", end_of_field, 1'b0);
        end
    end

    // Load leff bits (bit 0 first) using length code code.
    task automatic load_field(input int code, input int leff, input logic [63:0] pat);
        len_code  = LEN_W'(code);
        load_mode = 1'b1;
        shift_en  = 1'b1;
        for (int i = 0; i < leff; i++) begin
            ser_in = pat[i];
            @(posedge clk); #1;
        end
        shift_en  = 1'b0;
        load_mode = 1'b0;
        ser_in    = 1'b0;
        @(negedge clk);
        // R2: after L load shifts the first loaded bit is at the output
        chk("R2 first bit", ser_out, pat[0]);
        @(posedge clk); #1;
    endtask

    // Run n shifts; optional 3-cycle pause before shift number hold_at.
    task automatic run_field(input int leff, input logic [63:0] pat, input int n,
                             input int hold_at);
        for (int k = 0; k < n; k++) begin
            if (k == hold_at) begin
                for (int h = 0; h < 3; h++) begin
                    shift_en = 1'b0;
                    @(negedge clk);
                    // R7: output holds the pending bit; R9: no strobe
                    chk("R7 hold data", ser_out, pat[k % leff]);
                    chk("R9 eof idle", end_of_field, 1'b0);
                    @(posedge clk); #1;
                end
            end
            exp_q.push_back({pat[k % leff], (k % leff) == leff - 1});
            shift_en = 1'b1;
            @(posedge clk); #1;
        end
        shift_en = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        // R1: values while reset is held
        chk("R1 out in reset", ser_out, 1'b0);
        chk("R1 eof in reset", end_of_field, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out after reset", ser_out, 1'b0);
        chk("R1 eof after reset", end_of_field, 1'b0);
        @(posedge clk); #1;

        // R4: 8-bit field with a pause mid pass
        load_field(8, 8, 64'hB4);
        run_field(8, 64'hB4, 20, 11);
        // R4: minimal length 1, value 0
        load_field(1, 1, 64'h0);
        run_field(1, 64'h0, 5, -1);
        // R5: code 0 acts as length 1
        load_field(0, 1, 64'h1);
        run_field(1, 64'h1, 5, 2);
        // R4: full length
        load_field(64, 64, 64'hDEADBEEF_0123A5C3);
        run_field(64, 64'hDEADBEEF_0123A5C3, 130, 70);
        // R6: code above MAX_LEN acts as 64
        load_field(100, 64, 64'h8F00_3C5A_9E71_0FF1);
        run_field(64, 64'h8F00_3C5A_9E71_0FF1, 70, -1);
        // R3: odd length, pause on the last bit of a pass
        load_field(5, 5, 64'b10110);
        run_field(5, 64'b10110, 18, 4);
        // R10: reload mid-pass restarts at bit 0
        load_field(63, 63, 64'h5A5A_0F0F_3333_C3C1);
        run_field(63, 64'h5A5A_0F0F_3333_C3C1, 30, -1);
        load_field(8, 8, 64'h6D);
        run_field(8, 64'h6D, 17, -1);

        repeat (2) @(posedge clk);
        chk("R3 queue drained", exp_q.size() == 0, 1'b1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule